// File: doc/BRIEF.md
# Clock Frequency Selection Controller

This controller decides which CPU clock setting a frequency synthesizer should run at. It produces the divider values and a ratio index for a downstream synthesizer model. After reset, it waits for an active-low power-good strobe. The first cycle in which that strobe is low, it captures five frequency-select straps and two output-current straps. From then on, those captured values are frozen.

The ratio index comes from the captured straps or from five software select bits, as chosen by an override input. The same index also picks the gear constant that the downstream model uses. When programmable mode is enabled, the block also outputs an active N/M pair. The output frequency is the gear constant times (N+3)/(M+3).

Software writes N and M through separate write strobes. Every write forms a candidate pair from the written value and the stored value of the other field. The candidate becomes active only if N+3 exceeds M+3. A one-cycle load strobe marks every change of the values handed downstream.

Top module: `clk_freq_sel`

## Requirements
- R1: The block captures `strap_fs` and `strap_ms` on the first clock edge after reset at which `pg_n` is low. The captured values appear on `latched_fs`/`latched_ms` one cycle later and `straps_valid` rises. Later levels of `pg_n` and the straps have no effect until the next reset.
- R2: From reset until the capture, `latched_fs` and `latched_ms` read 0 and `straps_valid` reads 0.
- R3: `ratio_idx` is registered. One cycle after the inputs, it equals `sw_sel` when `fs_ovr` is 1 and `latched_fs` when `fs_ovr` is 0. This holds in both programmable and strap modes.
- R4: `prog_active` follows `prog_en` one cycle later. While it is 0, `eff_n` and `eff_m` read 0.
- R5: Writes work as follows:
  - A write cycle is any cycle with `wr_n` or `wr_m` high. It forms a candidate from each strobed data input, or else the stored value of that field, and stores the candidate in both fields.
  - The candidate becomes the active pair only if N > M, that is (N+3) > (M+3). Otherwise `cfg_invalid` is set and the previous active pair is held.
  - An accepted write clears `cfg_invalid`.
  - Both the stored and the active pair reset to N=127, M=45.
  - With `prog_en` high, `eff_n`/`eff_m` show the active pair two cycles after the write strobe.
- R6: `load_stb` is high for exactly the cycles in which `ratio_idx`, `eff_n` or `eff_m` differs from its value in the previous cycle.
- R7: `mult_x` equals 4 plus the 2-bit multiplier code. The code is `sw_ms` when `ms_ovr` is 1, else `latched_ms`. This path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_n | input | 1 | Active-low power-good strobe |
| strap_fs | input | 5 | Frequency-select straps |
| strap_ms | input | 2 | Output-current multiplier straps |
| sw_sel | input | 5 | Software frequency select |
| fs_ovr | input | 1 | 1 = use software select for the ratio index |
| prog_en | input | 1 | Programmable N/M mode enable |
| wr_n_data | input | 8 | N value to write |
| wr_n | input | 1 | N write strobe |
| wr_m_data | input | 7 | M value to write |
| wr_m | input | 1 | M write strobe |
| ms_ovr | input | 1 | 1 = software multiplier code |
| sw_ms | input | 2 | Software multiplier code |
| straps_valid | output | 1 | Straps have been captured |
| latched_fs | output | 5 | Captured frequency straps |
| latched_ms | output | 2 | Captured multiplier straps |
| mult_x | output | 3 | Current multiplier, 4..7 |
| ratio_idx | output | 5 | Active ratio / gear index |
| eff_n | output | 8 | Active N (0 when not programmable) |
| eff_m | output | 7 | Active M (0 when not programmable) |
| prog_active | output | 1 | Programmable mode in effect |
| cfg_invalid | output | 1 | Last write rejected |
| load_stb | output | 1 | One-cycle change strobe |

## Verification
A wrong capture flag shows up in two ways on the next cycle: `latched_fs` moves after capture, or `straps_valid` rises without a low strobe. Broken pair storage shows up on `eff_n`/`eff_m` two cycles after a write. One example is an active pair that accepts N ≤ M. Another is a stored field that loses the value of the field not written. A stale output register shows up as a `load_stb` that is missing or extra in the cycle after the change. The bench compares every output against a behavioural model on every cycle, so any such divergence is reported within one or two cycles.

// File: rtl/clk_freq_sel.sv
module clk_freq_sel #(
  parameter int FS_W      = 5,
  parameter int MS_W      = 2,
  parameter int N_W       = 8,
  parameter int M_W       = 7,
  parameter int MULT_BASE = 4,
  parameter int PRESET_N  = 127,
  parameter int PRESET_M  = 45
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_n,
  input  logic [FS_W-1:0] strap_fs,
  input  logic [MS_W-1:0] strap_ms,
  input  logic [FS_W-1:0] sw_sel,
  input  logic            fs_ovr,
  input  logic            prog_en,
  input  logic [N_W-1:0]  wr_n_data,
  input  logic            wr_n,
  input  logic [M_W-1:0]  wr_m_data,
  input  logic            wr_m,
  input  logic            ms_ovr,
  input  logic [MS_W-1:0] sw_ms,
  output logic            straps_valid,
  output logic [FS_W-1:0] latched_fs,
  output logic [MS_W-1:0] latched_ms,
  output logic [$clog2(MULT_BASE + (1 << MS_W))-1:0] mult_x,
  output logic [FS_W-1:0] ratio_idx,
  output logic [N_W-1:0]  eff_n,
  output logic [M_W-1:0]  eff_m,
  output logic            prog_active,
  output logic            cfg_invalid,
  output logic            load_stb
);
  localparam int MX_W = $clog2(MULT_BASE + (1 << MS_W));
  localparam int CW   = ((N_W > M_W) ? N_W : M_W) + 1;

  // strap capture
  logic            seen_q;
  logic [FS_W-1:0] fs_q;
  logic [MS_W-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      fs_q   <= '0;
      ms_q   <= '0;
    end else if (!seen_q && !pg_n) begin
      seen_q <= 1'b1;
      fs_q   <= strap_fs;
      ms_q   <= strap_ms;
    end
  end

  assign straps_valid = seen_q;
  assign latched_fs   = fs_q;
  assign latched_ms   = ms_q;
  assign mult_x       = MX_W'(MULT_BASE) + MX_W'(ms_ovr ? sw_ms : ms_q);

  // programmed pair
  logic [N_W-1:0] sn_q, an_q, cand_n;
  logic [M_W-1:0] sm_q, am_q, cand_m;
  logic           inv_q, any_wr, cand_ok;

  assign any_wr  = wr_n | wr_m;
  assign cand_n  = wr_n ? wr_n_data : sn_q;
  assign cand_m  = wr_m ? wr_m_data : sm_q;
  assign cand_ok = CW'(cand_n) > CW'(cand_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sn_q  <= N_W'(PRESET_N);
      sm_q  <= M_W'(PRESET_M);
      an_q  <= N_W'(PRESET_N);
      am_q  <= M_W'(PRESET_M);
      inv_q <= 1'b0;
    end else if (any_wr) begin
      sn_q <= cand_n;
      sm_q <= cand_m;
      if (cand_ok) begin
        an_q  <= cand_n;
        am_q  <= cand_m;
        inv_q <= 1'b0;
      end else begin
        inv_q <= 1'b1;
      end
    end
  end

  assign cfg_invalid = inv_q;

  // registered outputs and change strobe
  logic [FS_W-1:0] idx_d, idx_q;
  logic [N_W-1:0]  n_d, n_q;
  logic [M_W-1:0]  m_d, m_q;
  logic            pa_q, stb_q;

  assign idx_d = fs_ovr ? sw_sel : fs_q;
  assign n_d   = prog_en ? an_q : '0;
  assign m_d   = prog_en ? am_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      n_q   <= '0;
      m_q   <= '0;
      pa_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      n_q   <= n_d;
      m_q   <= m_d;
      pa_q  <= prog_en;
      stb_q <= (idx_d != idx_q) || (n_d != n_q) || (m_d != m_q);
    end
  end

  assign ratio_idx   = idx_q;
  assign eff_n       = n_q;
  assign eff_m       = m_q;
  assign prog_active = pa_q;
  assign load_stb    = stb_q;

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seen_q) |-> ($stable(latched_fs) && $stable(latched_ms))); // R1
  AST_PRECAPTURE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |-> (latched_fs == '0 && latched_ms == '0)); // R2
  AST_SW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    fs_ovr |=> (ratio_idx == $past(sw_sel))); // R3
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (!prog_active && eff_n == '0 && eff_m == '0)); // R4
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    prog_active |-> (CW'(eff_n) > CW'(eff_m))); // R5
  AST_STB_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_idx != $past(ratio_idx) || eff_n != $past(eff_n) || eff_m != $past(eff_m)) |-> load_stb); // R6
endmodule

// File: tb/sim_clk_freq_sel.sv
module sim_clk_freq_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pg_n = 1'b1, fs_ovr = 1'b0, prog_en = 1'b0;
  logic wr_n = 1'b0, wr_m = 1'b0, ms_ovr = 1'b0;
  logic [4:0] strap_fs = 5'h13, sw_sel = 5'h0;
  logic [1:0] strap_ms = 2'd2, sw_ms = 2'd0;
  logic [7:0] wr_n_data = 8'd0;
  logic [6:0] wr_m_data = 7'd0;
  logic       straps_valid, prog_active, cfg_invalid, load_stb;
  logic [4:0] latched_fs, ratio_idx;
  logic [1:0] latched_ms;
  logic [2:0] mult_x;
  logic [7:0] eff_n;
  logic [6:0] eff_m;

  always #4 clk = ~clk;

  clk_freq_sel u0 (.clk(clk), .rst_n(rst_n), .pg_n(pg_n), .strap_fs(strap_fs),
    .strap_ms(strap_ms), .sw_sel(sw_sel), .fs_ovr(fs_ovr), .prog_en(prog_en),
    .wr_n_data(wr_n_data), .wr_n(wr_n), .wr_m_data(wr_m_data), .wr_m(wr_m),
    .ms_ovr(ms_ovr), .sw_ms(sw_ms), .straps_valid(straps_valid),
    .latched_fs(latched_fs), .latched_ms(latched_ms), .mult_x(mult_x),
    .ratio_idx(ratio_idx), .eff_n(eff_n), .eff_m(eff_m), .prog_active(prog_active),
    .cfg_invalid(cfg_invalid), .load_stb(load_stb));

  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int m_seen = 0, m_fs = 0, m_ms = 0, m_sn = 127, m_sm = 45, m_an = 127, m_am = 45;
  int m_inv = 0, m_idx = 0, m_n = 0, m_m = 0, m_pa = 0, m_stb = 0;

  always @(posedge clk) begin
    int nidx, nn, nm, cn, cm;
    started <= 1;
    if (!rst_n) begin
      m_seen = 0; m_fs = 0; m_ms = 0; m_sn = 127; m_sm = 45; m_an = 127; m_am = 45;
      m_inv = 0; m_idx = 0; m_n = 0; m_m = 0; m_pa = 0; m_stb = 0;
    end else begin
      nidx = fs_ovr ? int'(sw_sel) : m_fs;
      nn = prog_en ? m_an : 0;
      nm = prog_en ? m_am : 0;
      m_stb = (nidx != m_idx || nn != m_n || nm != m_m) ? 1 : 0;
      m_idx = nidx; m_n = nn; m_m = nm; m_pa = int'(prog_en);
      if (m_seen == 0 && !pg_n) begin
        m_seen = 1; m_fs = int'(strap_fs); m_ms = int'(strap_ms);
      end
      if (wr_n || wr_m) begin
        cn = wr_n ? int'(wr_n_data) : m_sn;
        cm = wr_m ? int'(wr_m_data) : m_sm;
        m_sn = cn; m_sm = cm;
        if (cn + 3 > cm + 3) begin m_an = cn; m_am = cm; m_inv = 0; end
        else m_inv = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(m_seen != 0 ? "R1" : "R2", "latched_fs", int'(latched_fs), m_fs);
      chk(m_seen != 0 ? "R1" : "R2", "latched_ms", int'(latched_ms), m_ms);
      chk("R2", "straps_valid", int'(straps_valid), m_seen);
      chk("R3", "ratio_idx", int'(ratio_idx), m_idx);
      chk("R4", "prog_active", int'(prog_active), m_pa);
      chk("R5", "eff_n", int'(eff_n), m_n);
      chk("R5", "eff_m", int'(eff_m), m_m);
      chk("R5", "cfg_invalid", int'(cfg_invalid), m_inv);
      chk("R6", "load_stb", int'(load_stb), m_stb);
      chk("R7", "mult_x", int'(mult_x), 4 + (ms_ovr ? int'(sw_ms) : m_ms));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit dn, input int nv, input bit dm, input int mv);
    wr_n = dn; wr_n_data = 8'(nv); wr_m = dm; wr_m_data = 7'(mv);
    step(1);
    wr_n = 0; wr_m = 0;
    step(3);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2); strap_fs = 5'h07; strap_ms = 2'd1; step(2);        // R2 no capture while pg_n high
    strap_fs = 5'h1A; strap_ms = 2'd3; pg_n = 0; step(1);       // R1 capture
    pg_n = 1; strap_fs = 5'h00; strap_ms = 2'd0; step(2);
    pg_n = 0; strap_fs = 5'h05; step(3);                        // R1 ignored afterwards
    fs_ovr = 1; sw_sel = 5'd9; step(3);                         // R3
    fs_ovr = 0; step(2);
    prog_en = 1; step(3);                                       // R4
    wr(1, 200, 0, 0);                                           // R5 valid N only
    wr(0, 0, 1, 100);                                           // R5 M=100 < 200
    wr(0, 0, 1, 127); wr(1, 127, 0, 0);                         // R5 equal -> invalid
    wr(1, 128, 0, 0);                                           // R5 N=M+1 boundary
    wr(1, 10, 1, 50);                                           // R5 both strobes invalid
    wr(1, 51, 1, 50);                                           // R5 both strobes valid
    fs_ovr = 1; sw_sel = 5'd31; step(2);                        // R3 in programmable mode
    prog_en = 0; step(2);
    ms_ovr = 1; sw_ms = 2'd0; step(1); sw_ms = 2'd3; step(1);   // R7
    ms_ovr = 0; step(1);
    rst_n = 0; step(2); rst_n = 1; pg_n = 1; step(3);           // R2 after second reset
    for (int i = 0; i < 600; i++) begin
      pg_n = ($urandom_range(0, 7) != 0);
      strap_fs = 5'($urandom); strap_ms = 2'($urandom);
      sw_sel = 5'($urandom); fs_ovr = 1'($urandom); prog_en = ($urandom_range(0, 3) != 0);
      wr_n = ($urandom_range(0, 3) == 0); wr_m = ($urandom_range(0, 3) == 0);
      wr_n_data = 8'($urandom); wr_m_data = 7'($urandom);
      ms_ovr = 1'($urandom); sw_ms = 2'($urandom);
      step(1);
    end
    wr_n = 0; wr_m = 0;
    step(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule